// File: doc/BRIEF.md
# Synchronous FIFO with Guarded Flags

A single-clock first-in first-out buffer over an internal simple dual-port word store. A producer presents a word, a mask of byte lanes and a write request. A consumer raises a read request and takes the word from the data output. The buffer reports full, empty, an early-full flag, an early-empty flag and a stored-word count. All of these flags come from one pair of read and write pointers, each one bit wider than the address.

A parameter picks one of two read styles. In the registered style, a requested word appears one edge after the request and is then held. In the look-ahead style, the oldest stored word is always on the output, and a read request steps to the next word. Optional guards drop a write that arrives while full and a read that arrives while empty, so the pointers never cross. Partial writes update only the enabled byte lanes of the target location. A synchronous clear input and the active-low asynchronous reset both return the buffer to empty.

Top module: `sync_fifo_guarded`

## Requirements
- R1: Accepted words leave in the order they were accepted. The capacity is 2**ADDR_W words.
- R2: With OVF_GUARD set, a write request while full_o is high is dropped. No memory byte changes, and the count and write pointer stay unchanged.
- R3: With UNF_GUARD set, a read request while empty_o is high is dropped. The read pointer and the count stay unchanged, and the registered-style output holds its value.
- R4: empty_o is high exactly when occupancy is 0, and full_o is high exactly when occupancy is 2**ADDR_W. count_o equals occupancy modulo 2**ADDR_W, so it reads 0 when full.
- R5: almost_full_o is high exactly when occupancy >= AF_LEVEL, where occupancy is the true count from 0 to 2**ADDR_W.
- R6: almost_empty_o is high exactly when occupancy < AE_LEVEL.
- R7: With RD_MODE = RD_NORMAL, rd_data_o takes the head word at the edge that accepts a read. It holds that value until the next accepted read.
- R8: With RD_MODE = RD_SHOW_AHEAD, rd_data_o shows the head word whenever the buffer is not empty. An accepted read makes the next word visible after that edge.
- R9: wr_be_i bit b enables data bits [b*BYTE_W +: BYTE_W]. Disabled lanes of the written location keep their previous contents.
- R10: When a write and a read are both accepted in the same cycle, the occupancy is unchanged.
- R11: sclr_i high at an edge empties the buffer and takes priority over both requests. After that edge the count is 0, full_o and almost_full_o are low, and the registered-style output is 0.
- R12: rst_ni low clears the state at once, without waiting for a clock edge. The results are the same as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| sclr_i | input | 1 | Synchronous clear |
| wr_req_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to write |
| wr_be_i | input | DATA_W/BYTE_W | Byte-lane write enables |
| rd_req_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Read word |
| full_o | output | 1 | Buffer holds 2**ADDR_W words |
| empty_o | output | 1 | Buffer holds no words |
| almost_full_o | output | 1 | Occupancy at or above AF_LEVEL |
| almost_empty_o | output | 1 | Occupancy below AE_LEVEL |
| count_o | output | ADDR_W | Occupancy modulo 2**ADDR_W |

## Verification
The flags and the count come straight from registered pointers, so they change at the first rising edge after a request. The registered-style output changes at that same edge. The look-ahead output follows the updated pointer and memory right after that edge, and the asynchronous reset takes effect with no edge at all. The bench changes its inputs on the falling edge and samples every result 1 ns after each rising edge. It compares each result with a scoreboard that models the pointers, the guards and byte-lane merging. For the reset, it samples 1 ns after pulling rst_ni low, between edges.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic {
    RD_NORMAL     = 1'b0,
    RD_SHOW_AHEAD = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/sfg_mem.sv
module sfg_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [DATA_W/BYTE_W-1:0]   be_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  output logic [DATA_W-1:0]          rdata_o
);
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int NBYTES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // lane-masked write
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (be_i[b]) mem_q[waddr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sfg_ctrl.sv
module sfg_ctrl #(
  parameter int ADDR_W    = 3,
  parameter int AF_LEVEL  = 6,
  parameter int AE_LEVEL  = 2,
  parameter bit OVF_GUARD = 1'b1,
  parameter bit UNF_GUARD = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclr_i,
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              almost_full_o,
  output logic              almost_empty_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 2 ** ADDR_W;

  logic [PW-1:0] wr_ptr_q, rd_ptr_q, occ;
  logic          wr_block, rd_block;

  // extra pointer bit separates full from empty
  assign occ      = wr_ptr_q - rd_ptr_q;
  assign full_o   = occ[ADDR_W];
  assign empty_o  = (occ == '0);
  assign count_o  = occ[ADDR_W-1:0];

  assign almost_full_o  = (occ >= PW'(AF_LEVEL));
  assign almost_empty_o = (occ <  PW'(AE_LEVEL));

  assign wr_block = OVF_GUARD & full_o;
  assign rd_block = UNF_GUARD & empty_o;
  assign wr_en_o  = wr_req_i & ~wr_block & ~sclr_i;
  assign rd_en_o  = rd_req_i & ~rd_block & ~sclr_i;

  assign wr_addr_o = wr_ptr_q[ADDR_W-1:0];
  assign rd_addr_o = rd_ptr_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (sclr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_o) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (rd_en_o) rd_ptr_q <= rd_ptr_q + PW'(1);
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OVF_GUARD && full_o && wr_req_i && !sclr_i) |=> $stable(wr_ptr_q));

  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (UNF_GUARD && empty_o && rd_req_i && !sclr_i) |=> $stable(rd_ptr_q));

  a_r4_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r10_balanced_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && rd_en_o && !sclr_i) |=> $stable(occ));

  a_r11_sclr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclr_i |=> (empty_o && !full_o && !almost_full_o));

  if (OVF_GUARD && UNF_GUARD) begin : g_bound
    a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ <= PW'(DEPTH));
  end
endmodule

// File: rtl/sync_fifo_guarded.sv
module sync_fifo_guarded
  import sfg_pkg::*;
#(
  parameter int       DATA_W    = 16,
  parameter int       ADDR_W    = 3,
  parameter int       BYTE_W    = 8,
  parameter int       AF_LEVEL  = 6,
  parameter int       AE_LEVEL  = 2,
  parameter rd_mode_e RD_MODE   = RD_NORMAL,
  parameter bit       OVF_GUARD = 1'b1,
  parameter bit       UNF_GUARD = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclr_i,
  input  logic                     wr_req_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [DATA_W/BYTE_W-1:0] wr_be_i,
  input  logic                     rd_req_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     full_o,
  output logic                     empty_o,
  output logic                     almost_full_o,
  output logic                     almost_empty_o,
  output logic [ADDR_W-1:0]        count_o
);
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] head;

  sfg_ctrl #(
    .ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL),
    .OVF_GUARD(OVF_GUARD), .UNF_GUARD(UNF_GUARD)
  ) u_ctrl (
    .clk_i, .rst_ni, .sclr_i, .wr_req_i, .rd_req_i,
    .wr_en_o(wr_en), .rd_en_o(rd_en),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .count_o, .full_o, .empty_o, .almost_full_o, .almost_empty_o
  );

  sfg_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mem (
    .clk_i, .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data_i),
    .be_i(wr_be_i), .raddr_i(rd_addr), .rdata_o(head)
  );

  if (RD_MODE == RD_SHOW_AHEAD) begin : g_show_ahead
    assign rd_data_o = head;
  end else begin : g_normal
    logic [DATA_W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q <= '0;
      else if (sclr_i) q_q <= '0;
      else if (rd_en)  q_q <= head;
    end
    assign rd_data_o = q_q;

    a_r7_q_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_en && !sclr_i) |=> $stable(rd_data_o));
  end
endmodule

// File: tb/sync_fifo_guarded_tb_top.sv
module sync_fifo_guarded_tb_top;
  localparam int DW = 16, AW = 3, BW = 8, NB = DW / BW, DEPTH = 8, AF = 6, AE = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0, sclr = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_be = '0;
  logic [DW-1:0] q_n, q_s;
  logic          full_n, empty_n, af_n, ae_n, full_s, empty_s, af_s, ae_s;
  logic [AW-1:0] cnt_n, cnt_s;

  sync_fifo_guarded #(.DATA_W(DW), .ADDR_W(AW), .BYTE_W(BW), .AF_LEVEL(AF), .AE_LEVEL(AE),
    .RD_MODE(sfg_pkg::RD_NORMAL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclr_i(sclr), .wr_req_i(wr_req), .wr_data_i(wr_data),
    .wr_be_i(wr_be), .rd_req_i(rd_req), .rd_data_o(q_n), .full_o(full_n), .empty_o(empty_n),
    .almost_full_o(af_n), .almost_empty_o(ae_n), .count_o(cnt_n));

  sync_fifo_guarded #(.DATA_W(DW), .ADDR_W(AW), .BYTE_W(BW), .AF_LEVEL(AF), .AE_LEVEL(AE),
    .RD_MODE(sfg_pkg::RD_SHOW_AHEAD)) dut_sa_i (
    .clk_i(clk), .rst_ni(rst_n), .sclr_i(sclr), .wr_req_i(wr_req), .wr_data_i(wr_data),
    .wr_be_i(wr_be), .rd_req_i(rd_req), .rd_data_o(q_s), .full_o(full_s), .empty_o(empty_s),
    .almost_full_o(af_s), .almost_empty_o(ae_s), .count_o(cnt_s));

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] mem_m [DEPTH];
  int wp = 0, rp = 0, occ = 0;
  logic [DW-1:0] q_exp = '0;
  string tag = "R12 reset";

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    check("R4 empty",        32'(empty_n), 32'(occ == 0));
    check("R4 full",         32'(full_n),  32'(occ == DEPTH));
    check("R4 count",        32'(cnt_n),   32'(occ % DEPTH));
    check("R5 almost_full",  32'(af_n),    32'(occ >= AF));
    check("R6 almost_empty", 32'(ae_n),    32'(occ < AE));
    check("R7 q registered", 32'(q_n),     32'(q_exp));
    check("R4 sa empty",     32'(empty_s), 32'(occ == 0));
    check("R4 sa count",     32'(cnt_s),   32'(occ % DEPTH));
    check("R5 sa af",        32'(af_s),    32'(occ >= AF));
    check("R6 sa ae",        32'(ae_s),    32'(occ < AE));
    check("R4 sa full",      32'(full_s),  32'(occ == DEPTH));
    if (occ > 0) check("R8 q look-ahead", 32'(q_s), 32'(mem_m[rp]));
  endtask

  task automatic model(logic w, logic [DW-1:0] d, logic [NB-1:0] be, logic r, logic sc);
    logic wok, rok;
    wok = w && (occ != DEPTH);
    rok = r && (occ != 0);
    if (sc) begin
      wp = 0; rp = 0; occ = 0; q_exp = '0;
    end else begin
      if (rok) begin
        q_exp = mem_m[rp];
        rp = (rp + 1) % DEPTH;
      end
      if (wok) begin
        for (int b = 0; b < NB; b++)
          if (be[b]) mem_m[wp][b*BW +: BW] = d[b*BW +: BW];
        wp = (wp + 1) % DEPTH;
      end
      occ = occ + int'(wok) - int'(rok);
    end
  endtask

  task automatic step(logic w, logic [DW-1:0] d, logic [NB-1:0] be, logic r, logic sc);
    @(negedge clk);
    wr_req = w; wr_data = d; wr_be = be; rd_req = r; sclr = sc;
    @(posedge clk);
    model(w, d, be, r, sc);
    #1;
    check_outputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL [watchdog] run hung: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    #1 check_outputs();                     // R12 reset state
    rst_n = 1'b1;

    // R1 fill with full lanes, R2 writes while full
    tag = "R1 fill";
    for (int i = 0; i < DEPTH; i++) step(1'b1, 16'h1000 + 16'(i * 16'h0111), 2'b11, 1'b0, 1'b0);
    tag = "R2 overflow guard";
    step(1'b1, 16'hDEAD, 2'b11, 1'b0, 1'b0);
    step(1'b1, 16'hBEEF, 2'b01, 1'b0, 1'b0);
    check("R2 count held at full", 32'(full_n), 32'd1);
    tag = "R1 drain order";
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, '0, 1'b1, 1'b0);
    tag = "R3 underflow guard";
    step(1'b0, '0, '0, 1'b1, 1'b0);
    step(1'b0, '0, '0, 1'b1, 1'b0);
    check("R3 q held after empty read", 32'(q_n), 32'(q_exp));

    // R9 lane-mask sweep over all masks and locations
    tag = "R9 byte lanes";
    for (int round = 0; round < 4; round++) begin
      for (int i = 0; i < DEPTH; i++)
        step(1'b1, 16'(round * 16'h2345 + i * 16'h0101 + 16'h0F0F), NB'(i + round), 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++) step(1'b0, '0, '0, 1'b1, 1'b0);
    end

    // R10 simultaneous accept at mid occupancy
    tag = "R10 simultaneous";
    for (int i = 0; i < 4; i++) step(1'b1, 16'hA000 + 16'(i), 2'b11, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 16'hB000 + 16'(i), 2'b11, 1'b1, 1'b0);
    check("R10 count unchanged", 32'(cnt_n), 32'd4);

    // R11 sync clear beats pending requests
    tag = "R11 sync clear";
    step(1'b1, 16'hC0DE, 2'b11, 1'b1, 1'b1);
    check("R11 empty after clear", 32'(empty_n), 32'd1);
    step(1'b1, 16'h5A5A, 2'b11, 1'b0, 1'b0);

    // mixed traffic
    tag = "R10 mixed traffic";
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], {lfsr[7:0], lfsr[15:8]}, lfsr[5:4], lfsr[1] ^ lfsr[6],
           lfsr[15:10] == 6'h3F);
    end

    // R12 asynchronous clear between edges
    tag = "R12 async clear";
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0; sclr = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b1, 16'h7700 + 16'(i), 2'b11, 1'b0, 1'b0);
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    rst_n = 1'b0;
    #1;
    wp = 0; rp = 0; occ = 0; q_exp = '0;
    check_outputs();
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 16'h1234, 2'b11, 1'b0, 1'b0);
    step(1'b0, '0, '0, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule